// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is a cycle-based model of a one-time-programmable memory read port. The stored array is organised as 16-bit words. A width select decides how each read is presented. In word mode the full word appears on the 16-bit data bus. In byte mode a shared line stops carrying data bit 15 and becomes the least significant address bit. It picks either the low or the high half of the addressed word, and that half is presented on data lines 0 to 7. Three drive flags tell the surrounding logic which groups of data lines would be actively driven: lines 0 to 7, lines 8 to 14, and line 15.

Data is gated by two active-low controls. Chip enable selects the device, and standby overrides everything else. Output enable gates the lines. Access time is modelled in clock cycles, derived from nanosecond parameters and the clock period. The output-enable path takes half as long as the address and chip-enable path. A data-valid flag rises only when both delays have elapsed.

An identifier mode returns a fixed maker code or device code in place of stored data. The array starts fully erased (all ones). A program port can only clear bits.

Top module: `dual_width_rom`

## Requirements
- R1: With `wide_i`=1 and a valid read, `data_o` equals the full stored word at `addr_i`, and all three drive flags are 1.
- R2: With `wide_i`=0, `lsb_i`=0 places bits 7:0 of the word on `data_o[7:0]` and `lsb_i`=1 places bits 15:8 there; in this mode `data_o[15:8]` reads 0, `drv_lo_o`=1, and `drv_mid_o`=`drv_top_o`=0.
- R3: Drive flags and `valid_o` are 1 only when both `ce_n_i` and `oe_n_i` were 0 at the previous clock edge; with `oe_n_i`=1 all flags are 0.
- R4: With `ce_n_i`=1 (standby), all drive flags and `valid_o` are 0 after the next edge, whatever `oe_n_i` is.
- R5: With `id_mode_i`=1, `addr_i[0]`=0 reads 16'h0020 and `addr_i[0]`=1 reads 16'h0032; the upper byte is always 0.
- R6: After reset, every word reads 16'hFFFF.
- R7: A program write stores the bitwise AND of the old word and `prog_data_i`; a bit at 0 never returns to 1.
- R8: The access count restarts on a change of `addr_i`, `wide_i`, or `id_mode_i`, on a change of `lsb_i` in byte mode, and while `ce_n_i`=1. `valid_o` rises at the ACC-th edge after the restart (ACC = ceil(ACC_NS/CLK_NS), 20 by default). In word mode, a change of `lsb_i` does not restart the count.
- R9: With the address stable, `valid_o` rises at the OE-th edge after `oe_n_i` falls (OE = ceil(OE_NS/CLK_NS), 10 by default).
- R10: While `valid_o` is 0, `data_o` keeps its last value.
- R11: During reset, `data_o` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, erases array |
| addr_i | input | ADDR_W | Word address |
| lsb_i | input | 1 | Shared line: byte select in byte mode |
| wide_i | input | 1 | 1 = word mode, 0 = byte mode |
| ce_n_i | input | 1 | Active-low chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| id_mode_i | input | 1 | Identifier readout select |
| prog_we_i | input | 1 | Program write strobe |
| prog_addr_i | input | ADDR_W | Program word address |
| prog_data_i | input | 16 | Program data (only zeros take effect) |
| data_o | output | 16 | Read data |
| drv_lo_o | output | 1 | Lines 7:0 driven |
| drv_mid_o | output | 1 | Lines 14:8 driven |
| drv_top_o | output | 1 | Line 15 driven |
| valid_o | output | 1 | Access delay elapsed, data valid |

## Verification
The read path is exercised by a vector table. It covers word reads of programmed, erased and re-programmed words, byte reads of both halves of words with different upper and lower bytes, and identifier reads with both parities of address bit 0, in both widths. These vectors separate a swapped byte select, a missing upper-byte clear, and an OR in place of an AND on programming. Every vector is also sampled one edge before its expected valid point, which catches an off-by-one delay and a failure to hold the previous data. Directed cases then separate the chip-enable delay from the output-enable delay, and show that the shared line is ignored for timing in word mode.

// File: rtl/rom_pkg.sv
package rom_pkg;
    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction
endpackage

// File: rtl/rom_cell_array.sv
module rom_cell_array
    import rom_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_word_o
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_d [WORDS];
    logic [DATA_W-1:0] cell_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            cell_d[i] = cell_q[i];
        end
        if (wr_en_i) begin
            cell_d[wr_addr_i] = cell_q[wr_addr_i] & wr_data_i;
        end
        rd_word_o = cell_q[rd_addr_i];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) cell_q[i] <= '1;
            else        cell_q[i] <= cell_d[i];
        end
    end

    // A programmed zero must stay zero in every word.
    for (genvar g = 0; g < WORDS; g++) begin : g_clr_chk
        assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((~$past(cell_q[g]) & cell_q[g]) == '0));
    end
endmodule

// File: rtl/rom_access_timer.sv
module rom_access_timer #(
    parameter int ACC_CYC = 20,
    parameter int OE_CYC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_active_i,
    input  logic oe_active_i,
    input  logic restart_i,
    output logic ready_o
);
    localparam int AW = $clog2(ACC_CYC + 1);
    localparam int OW = $clog2(OE_CYC + 1);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [OW-1:0] oe;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!ce_active_i)                   tmr_d.acc = '0;
        else if (restart_i)                 tmr_d.acc = AW'(1);
        else if (tmr_q.acc != AW'(ACC_CYC)) tmr_d.acc = tmr_q.acc + AW'(1);

        if (!oe_active_i)                   tmr_d.oe = '0;
        else if (tmr_q.oe != OW'(OE_CYC))   tmr_d.oe = tmr_q.oe + OW'(1);

        ready_o = (tmr_d.acc == AW'(ACC_CYC)) && (tmr_d.oe == OW'(OE_CYC));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assert_acc_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.acc <= AW'(ACC_CYC));
    assert_oe_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.oe <= OW'(OE_CYC));
    assert_standby_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_active_i |=> (tmr_q.acc == '0));
endmodule

// File: rtl/rom_lane_mux.sv
module rom_lane_mux
    import rom_pkg::*;
#(
    parameter logic [HALF_W-1:0] MAKER_CODE  = 8'h20,
    parameter logic [HALF_W-1:0] DEVICE_CODE = 8'h32
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              wide_i,
    input  logic              lsb_i,
    input  logic              id_mode_i,
    input  logic              a0_i,
    output logic [DATA_W-1:0] value_o
);
    always_comb begin
        if (id_mode_i)
            value_o = {{HALF_W{1'b0}}, (a0_i ? DEVICE_CODE : MAKER_CODE)};
        else if (wide_i)
            value_o = word_i;
        else if (lsb_i)
            value_o = {{HALF_W{1'b0}}, word_i[DATA_W-1:HALF_W]};
        else
            value_o = {{HALF_W{1'b0}}, word_i[HALF_W-1:0]};
    end
endmodule

// File: rtl/dual_width_rom.sv
module dual_width_rom
    import rom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CLK_NS = 4,
    parameter int ACC_NS = 80,
    parameter int OE_NS  = 40,
    parameter logic [7:0] MAKER_CODE  = 8'h20,
    parameter logic [7:0] DEVICE_CODE = 8'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              lsb_i,
    input  logic              wide_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              id_mode_i,
    input  logic              prog_we_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic [15:0]       prog_data_i,
    output logic [15:0]       data_o,
    output logic              drv_lo_o,
    output logic              drv_mid_o,
    output logic              drv_top_o,
    output logic              valid_o
);
    localparam int ACC_CYC = ns_to_cycles(ACC_NS, CLK_NS);
    localparam int OE_CYC  = ns_to_cycles(OE_NS, CLK_NS);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wide;
        logic              lsb;
        logic              id;
        logic [DATA_W-1:0] data;
        logic              drv_lo;
        logic              drv_mid;
        logic              drv_top;
        logic              valid;
    } port_t;

    port_t st_d, st_q;
    logic [DATA_W-1:0] word_w;
    logic [DATA_W-1:0] value_w;
    logic              restart_w;
    logic              ready_w;
    logic              enable_w;

    rom_cell_array #(.ADDR_W(ADDR_W)) cells_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (prog_we_i),
        .wr_addr_i (prog_addr_i),
        .wr_data_i (prog_data_i),
        .rd_addr_i (addr_i),
        .rd_word_o (word_w)
    );

    rom_lane_mux #(.MAKER_CODE(MAKER_CODE), .DEVICE_CODE(DEVICE_CODE)) mux_i (
        .word_i    (word_w),
        .wide_i    (wide_i),
        .lsb_i     (lsb_i),
        .id_mode_i (id_mode_i),
        .a0_i      (addr_i[0]),
        .value_o   (value_w)
    );

    rom_access_timer #(.ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_active_i (!ce_n_i),
        .oe_active_i (!oe_n_i),
        .restart_i   (restart_w),
        .ready_o     (ready_w)
    );

    always_comb begin
        // The shared line only counts as an address bit in byte mode.
        restart_w = (addr_i != st_q.addr) || (wide_i != st_q.wide)
                 || (id_mode_i != st_q.id) || (!wide_i && (lsb_i != st_q.lsb));
        enable_w  = !ce_n_i && !oe_n_i;

        st_d         = st_q;
        st_d.addr    = addr_i;
        st_d.wide    = wide_i;
        st_d.lsb     = lsb_i;
        st_d.id      = id_mode_i;
        st_d.drv_lo  = enable_w;
        st_d.drv_mid = enable_w && wide_i;
        st_d.drv_top = enable_w && wide_i;
        st_d.valid   = enable_w && ready_w;
        if (st_d.valid) st_d.data = value_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o    = st_q.data;
    assign drv_lo_o  = st_q.drv_lo;
    assign drv_mid_o = st_q.drv_mid;
    assign drv_top_o = st_q.drv_top;
    assign valid_o   = st_q.valid;

    assert_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |=> (!drv_lo_o && !drv_mid_o && !drv_top_o && !valid_o));
    assert_oe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |=> (!drv_lo_o && !valid_o));
    assert_byte_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |=> (!drv_mid_o && !drv_top_o));
    assert_id_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        id_mode_i |=> (!valid_o || data_o[15:8] == 8'h00));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));
endmodule

// File: tb/dual_width_rom_tb_top.sv
module dual_width_rom_tb_top;
    // 80 ns and 40 ns at a 4 ns clock
    localparam int ACC = 20;
    localparam int OE  = 10;
    localparam int NV  = 11;

    // {wide, lsb, id, addr[5:0], expected[15:0]}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 6'd3,  16'h0550},  // R1 R7 re-programmed word
        {1'b1, 1'b0, 1'b0, 6'd5,  16'h1234},  // R1
        {1'b0, 1'b0, 1'b0, 6'd5,  16'h0034},  // R2 low half
        {1'b0, 1'b1, 1'b0, 6'd5,  16'h0012},  // R2 high half
        {1'b0, 1'b1, 1'b0, 6'd63, 16'h0080},  // R2
        {1'b0, 1'b0, 1'b0, 6'd63, 16'h0001},  // R2
        {1'b1, 1'b0, 1'b0, 6'd0,  16'hFFFF},  // R6 erased
        {1'b1, 1'b0, 1'b1, 6'd0,  16'h0020},  // R5 maker
        {1'b1, 1'b0, 1'b1, 6'd1,  16'h0032},  // R5 device
        {1'b0, 1'b0, 1'b1, 6'd2,  16'h0020},  // R5 byte width
        {1'b1, 1'b0, 1'b0, 6'd63, 16'h8001}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        lsb = 1'b0, wide = 1'b1, ce_n = 1'b1, oe_n = 1'b1, idm = 1'b0;
    logic        pwe = 1'b0;
    logic [5:0]  paddr = '0;
    logic [15:0] pdata = '0;
    logic [15:0] data;
    logic        dlo, dmid, dtop, vld;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dual_width_rom dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .lsb_i(lsb), .wide_i(wide),
        .ce_n_i(ce_n), .oe_n_i(oe_n), .id_mode_i(idm), .prog_we_i(pwe),
        .prog_addr_i(paddr), .prog_data_i(pdata), .data_o(data),
        .drv_lo_o(dlo), .drv_mid_o(dmid), .drv_top_o(dtop), .valid_o(vld)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic prog(input logic [5:0] a, input logic [15:0] d);
        paddr = a; pdata = d; pwe = 1'b1;
        tick(1);
        pwe = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        @(negedge clk);
        tick(3);
        chk("R11 reset data", data, 16'h0000);
        chk("R11 reset flags", {dlo, dmid, dtop, vld}, 4'b0000);
        rst_n = 1'b1;
        tick(1);

        prog(6'd3, 16'hA55A);
        prog(6'd5, 16'h1234);
        prog(6'd3, 16'h0FF0);   // AND gives 0550
        prog(6'd63, 16'h8001);
        addr = 6'd9;
        tick(1);

        ce_n = 1'b0; oe_n = 1'b0;
        prev = 16'h0000;
        for (int i = 0; i < NV; i++) begin
            wide = VEC[i][24]; lsb = VEC[i][23]; idm = VEC[i][22]; addr = VEC[i][21:16];
            tick(ACC - 1);
            chk($sformatf("R8 valid low before delay vec%0d", i), vld, 1'b0);
            chk($sformatf("R10 hold vec%0d", i), data, prev);
            tick(1);
            chk($sformatf("R8 valid at delay vec%0d", i), vld, 1'b1);
            chk($sformatf("R1 R2 R5 data vec%0d", i), data, VEC[i][15:0]);
            chk($sformatf("R1 R2 flags vec%0d", i), {dlo, dmid, dtop}, {1'b1, VEC[i][24], VEC[i][24]});
            prev = VEC[i][15:0];
        end

        // Word mode: shared line is data, no restart (R8)
        lsb = 1'b1;
        tick(1);
        chk("R8 word-mode lsb no restart", vld, 1'b1);
        chk("R1 word data after lsb toggle", data, 16'h8001);

        // Output enable path (R3, R9)
        oe_n = 1'b1;
        tick(1);
        chk("R3 oe high flags", {dlo, dmid, dtop, vld}, 4'b0000);
        chk("R10 hold with oe high", data, 16'h8001);
        oe_n = 1'b0;
        tick(OE - 1);
        chk("R9 valid low before oe delay", vld, 1'b0);
        chk("R3 drive with both enables", dlo, 1'b1);
        tick(1);
        chk("R9 valid at oe delay", vld, 1'b1);

        // Standby (R4) then chip-enable delay (R8)
        ce_n = 1'b1;
        tick(1);
        chk("R4 standby oe low", {dlo, dmid, dtop, vld}, 4'b0000);
        oe_n = 1'b1;
        tick(1);
        chk("R4 standby oe high", {dlo, dmid, dtop, vld}, 4'b0000);
        oe_n = 1'b0;
        tick(3);
        ce_n = 1'b0;
        tick(ACC - 1);
        chk("R8 ce delay not elapsed", vld, 1'b0);
        tick(1);
        chk("R8 ce delay elapsed", vld, 1'b1);
        chk("R6 R7 data after standby", data, 16'h8001);

        // Byte read of an erased word, upper half (R6)
        wide = 1'b0; addr = 6'd10; lsb = 1'b1;
        tick(ACC);
        chk("R6 erased byte", data, 16'h00FF);

        // Programming ones has no effect (R7)
        ce_n = 1'b1;
        prog(6'd5, 16'hFFFF);
        ce_n = 1'b0; wide = 1'b1; addr = 6'd5;
        tick(ACC);
        chk("R7 no bit returns to one", data, 16'h1234);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule